// File: doc/BRIEF.md
# Configurable CPLD Macrocell Pair

This block models two neighbouring cells of a programmable logic block. The pin cell can drive a device pin. The hidden cell sits next to it and feeds only the routing fabric. Each cell ORs a masked group of product terms, can invert the result, and passes it to a storage element. That element is set by static configuration to work as a wire, a D flip-flop, a toggle flip-flop or a transparent latch. Configuration also picks, for each cell, which global clock line acts as its clock or latch enable.

The pin cell has a configuration bit that chooses between driving the pin and using it as an input. When the pin is an input, its level is forwarded to the routing fabric. The cell's own value stays available on a separate feedback output, so its register can still be used internally. The hidden cell can also be turned into an input register. In that case it captures the neighbouring pin level, either in a D flip-flop or in a latch, instead of its own product-term sum. An active-low asynchronous clear and an active-low asynchronous preset act on every storage element. Clear wins when both are low.

All configuration inputs are static: they change only while every global clock line is low.

Top module: `cpld_mc_pair`

## Requirements
- R1: A cell's sum is the OR of the product terms whose enable bit is 1. When no enable bit is set, the sum is 0 before polarity is applied.
- R2: When a cell's invert bit is 1, the sum is complemented before it reaches the storage element.
- R3: Mode code 0 (wire) makes the cell value follow the polarity-adjusted sum with no clock involved.
- R4: Mode code 1 (D flip-flop) captures the polarity-adjusted sum on the rising edge of the selected clock line. Select 0 picks `clk_i[0]` and select 1 picks `clk_i[1]`. Edges on the unselected line have no effect.
- R5: Mode code 2 (toggle flip-flop) inverts the stored value on a rising edge of the selected clock when the polarity-adjusted sum is 1, and keeps it when the sum is 0.
- R6: Mode code 3 (latch) passes the polarity-adjusted sum while the selected clock line is high and holds the value while it is low.
- R7: In modes 1, 2 and 3, `rst_ni` low forces the stored value to 0 at once and `set_ni` low forces it to 1 at once. With both low the value is 0. Mode 0 is not affected by either. When both are released, `set_ni` is released no later than `rst_ni`.
- R8: When `io_drive_i` is 1, `pin_oe_o` is 1, `pin_o` carries the pin cell value and `pin_fb_o` is 0. When `io_drive_i` is 0, `pin_oe_o` is 0 and `pin_fb_o` equals `pin_i`.
- R9: `io_fb_o` always carries the pin cell value, whatever the setting of `io_drive_i`.
- R10: The hidden cell value appears only on `bur_fb_o` and never affects `pin_o` or `pin_oe_o`.
- R11: When `bur_pin_reg_i` is 1, the hidden cell takes `pin_i` as its data and ignores its invert bit. It acts as a latch in mode 3 and as a D flip-flop in every other mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | NUM_CLK | Global clock / latch-enable lines |
| rst_ni | input | 1 | Asynchronous clear, active low |
| set_ni | input | 1 | Asynchronous preset, active low |
| pin_i | input | 1 | Level seen on the device pin |
| io_pt_i | input | NUM_PT | Product terms offered to the pin cell |
| io_pt_en_i | input | NUM_PT | Product-term enable mask, pin cell |
| io_inv_i | input | 1 | Invert the pin cell sum |
| io_mode_i | input | 2 | Pin cell mode: 0 wire, 1 D, 2 toggle, 3 latch |
| io_clk_sel_i | input | CLK_W | Clock line select, pin cell |
| io_drive_i | input | 1 | 1: pin is driven, 0: pin is an input |
| bur_pt_i | input | NUM_PT | Product terms offered to the hidden cell |
| bur_pt_en_i | input | NUM_PT | Product-term enable mask, hidden cell |
| bur_inv_i | input | 1 | Invert the hidden cell sum |
| bur_mode_i | input | 2 | Hidden cell mode, same codes as the pin cell |
| bur_clk_sel_i | input | CLK_W | Clock line select, hidden cell |
| bur_pin_reg_i | input | 1 | Hidden cell captures the pin level instead of its sum |
| pin_o | output | 1 | Value driven toward the pin |
| pin_oe_o | output | 1 | Pin output enable |
| io_fb_o | output | 1 | Pin cell value toward the routing fabric |
| pin_fb_o | output | 1 | Pin level forwarded when the pin is an input |
| bur_fb_o | output | 1 | Hidden cell value toward the routing fabric |

## Verification
The hardest states to reach are those that depend on which clock line a cell listens to. A missed clock selection only shows when the other line pulses alone. So `clk_i[0]` runs free and `clk_i[1]` is pulsed by the stimulus, only inside windows where `clk_i[0]` is low, and configuration changes in the same windows. The stimulus then reaches the input-register case by pulsing `clk_i[1]` alone, with the invert bit set and mode 2 selected, so that a wrongly applied polarity or a toggle leaves a visibly different value. For the clear-over-preset case, both are lowered together and preset is released first, so no clock edge can hide the ordering.

// File: rtl/cpld_mc_pkg.sv
package cpld_mc_pkg;
  typedef enum logic [1:0] {
    MC_WIRE  = 2'd0,
    MC_DFF   = 2'd1,
    MC_TFF   = 2'd2,
    MC_LATCH = 2'd3
  } mc_mode_e;
endpackage

// File: rtl/mc_sum.sv
module mc_sum #(
  parameter int NUM_PT = 16
) (
  input  logic [NUM_PT-1:0] pt_i,
  input  logic [NUM_PT-1:0] en_i,
  input  logic              inv_i,
  output logic              sum_o
);
  assign sum_o = (|(pt_i & en_i)) ^ inv_i;
endmodule

// File: rtl/mc_clk_mux.sv
module mc_clk_mux #(
  parameter int NUM_CLK = 2,
  localparam int CLK_W  = (NUM_CLK > 1) ? $clog2(NUM_CLK) : 1
) (
  input  logic [NUM_CLK-1:0] clk_i,
  input  logic [CLK_W-1:0]   sel_i,
  output logic               clk_o
);
  // select is static; changed only while all lines are low
  assign clk_o = clk_i[sel_i];
endmodule

// File: rtl/mc_store.sv
module mc_store
  import cpld_mc_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     set_ni,
  input  logic     d_i,
  input  mc_mode_e mode_i,
  output logic     q_o
);
  logic ff_q, ff_d, lat_q;

  assign ff_d = (mode_i == MC_TFF) ? (ff_q ^ d_i) : d_i;

  always_ff @(posedge clk_i or negedge rst_ni or negedge set_ni) begin
    if (!rst_ni)      ff_q <= 1'b0;
    else if (!set_ni) ff_q <= 1'b1;
    else              ff_q <= ff_d;
  end

  always_latch begin
    if (!rst_ni)      lat_q = 1'b0;
    else if (!set_ni) lat_q = 1'b1;
    else if (clk_i)   lat_q = d_i;
  end

  always_comb begin
    unique case (mode_i)
      MC_WIRE:  q_o = d_i;
      MC_LATCH: q_o = lat_q;
      default:  q_o = ff_q;
    endcase
  end
endmodule

// File: rtl/cpld_mc_pair.sv
module cpld_mc_pair
  import cpld_mc_pkg::*;
#(
  parameter int NUM_PT  = 16,
  parameter int NUM_CLK = 2,
  localparam int CLK_W  = (NUM_CLK > 1) ? $clog2(NUM_CLK) : 1
) (
  input  logic [NUM_CLK-1:0] clk_i,
  input  logic               rst_ni,
  input  logic               set_ni,
  input  logic               pin_i,
  input  logic [NUM_PT-1:0]  io_pt_i,
  input  logic [NUM_PT-1:0]  io_pt_en_i,
  input  logic               io_inv_i,
  input  logic [1:0]         io_mode_i,
  input  logic [CLK_W-1:0]   io_clk_sel_i,
  input  logic               io_drive_i,
  input  logic [NUM_PT-1:0]  bur_pt_i,
  input  logic [NUM_PT-1:0]  bur_pt_en_i,
  input  logic               bur_inv_i,
  input  logic [1:0]         bur_mode_i,
  input  logic [CLK_W-1:0]   bur_clk_sel_i,
  input  logic               bur_pin_reg_i,
  output logic               pin_o,
  output logic               pin_oe_o,
  output logic               io_fb_o,
  output logic               pin_fb_o,
  output logic               bur_fb_o
);
  localparam int NCELL = 2; // 0: pin cell, 1: hidden cell

  logic [NUM_PT-1:0] pt    [NCELL];
  logic [NUM_PT-1:0] pt_en [NCELL];
  logic [CLK_W-1:0]  csel  [NCELL];
  logic [NCELL-1:0]  inv, sum, cclk, d, q;
  mc_mode_e          mode  [NCELL];

  assign pt[0]    = io_pt_i;
  assign pt[1]    = bur_pt_i;
  assign pt_en[0] = io_pt_en_i;
  assign pt_en[1] = bur_pt_en_i;
  assign inv      = {bur_inv_i, io_inv_i};
  assign csel[0]  = io_clk_sel_i;
  assign csel[1]  = bur_clk_sel_i;

  // hidden cell as input register: pin data, D unless latch selected
  assign d[0]    = sum[0];
  assign d[1]    = bur_pin_reg_i ? pin_i : sum[1];
  assign mode[0] = mc_mode_e'(io_mode_i);
  assign mode[1] = (bur_pin_reg_i && mc_mode_e'(bur_mode_i) != MC_LATCH)
                   ? MC_DFF : mc_mode_e'(bur_mode_i);

  for (genvar c = 0; c < NCELL; c++) begin : g_cell
    mc_sum #(.NUM_PT(NUM_PT)) u_sum (
      .pt_i  (pt[c]),
      .en_i  (pt_en[c]),
      .inv_i (inv[c]),
      .sum_o (sum[c])
    );
    mc_clk_mux #(.NUM_CLK(NUM_CLK)) u_cmux (
      .clk_i (clk_i),
      .sel_i (csel[c]),
      .clk_o (cclk[c])
    );
    mc_store u_store (
      .clk_i  (cclk[c]),
      .rst_ni (rst_ni),
      .set_ni (set_ni),
      .d_i    (d[c]),
      .mode_i (mode[c]),
      .q_o    (q[c])
    );
  end

  assign pin_o    = q[0];
  assign pin_oe_o = io_drive_i;
  assign io_fb_o  = q[0];
  assign pin_fb_o = io_drive_i ? 1'b0 : pin_i;
  assign bur_fb_o = q[1];
endmodule

// File: rtl/cpld_mc_pair_chk.sv
module cpld_mc_pair_chk #(
  parameter int NUM_PT  = 16,
  parameter int NUM_CLK = 2,
  localparam int CLK_W  = (NUM_CLK > 1) ? $clog2(NUM_CLK) : 1
) (
  input logic [NUM_CLK-1:0] clk_i,
  input logic               rst_ni,
  input logic               set_ni,
  input logic               pin_i,
  input logic [NUM_PT-1:0]  io_pt_i,
  input logic [NUM_PT-1:0]  io_pt_en_i,
  input logic               io_inv_i,
  input logic [1:0]         io_mode_i,
  input logic [CLK_W-1:0]   io_clk_sel_i,
  input logic               io_drive_i,
  input logic [1:0]         bur_mode_i,
  input logic [CLK_W-1:0]   bur_clk_sel_i,
  input logic               bur_pin_reg_i,
  input logic               pin_o,
  input logic               pin_oe_o,
  input logic               io_fb_o,
  input logic               pin_fb_o,
  input logic               bur_fb_o
);
  logic io_sum;
  assign io_sum = (|(io_pt_i & io_pt_en_i)) ^ io_inv_i;

  AST_WIRE_FOLLOWS_SUM: assert property (@(posedge clk_i[0]) disable iff (!rst_ni)
    (io_mode_i == 2'd0 && io_drive_i) |-> (pin_oe_o && pin_o == io_sum)); // R3

  AST_PIN_FORWARD: assert property (@(posedge clk_i[0]) disable iff (!rst_ni)
    !io_drive_i |-> (!pin_oe_o && pin_fb_o == pin_i)); // R8

  AST_PRESET_HOLDS: assert property (@(posedge clk_i[0]) disable iff (!rst_ni)
    (!set_ni && io_mode_i != 2'd0) |-> io_fb_o); // R7

  AST_TOGGLE_STEP: assert property (@(posedge clk_i[0]) disable iff (!rst_ni || !set_ni)
    (io_mode_i == 2'd2 && io_clk_sel_i == '0) |=>
      (io_mode_i != 2'd2 || io_clk_sel_i != '0 ||
       io_fb_o == ($past(io_fb_o) ^ $past(io_sum)))); // R5

  AST_PIN_CAPTURE: assert property (@(posedge clk_i[1]) disable iff (!rst_ni || !set_ni)
    (bur_pin_reg_i && bur_mode_i == 2'd1 && bur_clk_sel_i == CLK_W'(1)) |=>
      (!bur_pin_reg_i || bur_mode_i != 2'd1 || bur_clk_sel_i != CLK_W'(1) ||
       bur_fb_o == $past(pin_i))); // R11
endmodule

bind cpld_mc_pair cpld_mc_pair_chk #(.NUM_PT(NUM_PT), .NUM_CLK(NUM_CLK)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .set_ni        (set_ni),
  .pin_i         (pin_i),
  .io_pt_i       (io_pt_i),
  .io_pt_en_i    (io_pt_en_i),
  .io_inv_i      (io_inv_i),
  .io_mode_i     (io_mode_i),
  .io_clk_sel_i  (io_clk_sel_i),
  .io_drive_i    (io_drive_i),
  .bur_mode_i    (bur_mode_i),
  .bur_clk_sel_i (bur_clk_sel_i),
  .bur_pin_reg_i (bur_pin_reg_i),
  .pin_o         (pin_o),
  .pin_oe_o      (pin_oe_o),
  .io_fb_o       (io_fb_o),
  .pin_fb_o      (pin_fb_o),
  .bur_fb_o      (bur_fb_o)
);

// File: tb/cpld_mc_pair_tb.sv
module cpld_mc_pair_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_PT     = 16;

  logic              clk0 = 1'b0, clk1 = 1'b0;
  logic              rst_ni, set_ni, pin_i;
  logic [NUM_PT-1:0] io_pt, io_en, bur_pt, bur_en;
  logic              io_inv, bur_inv, io_drive, bur_pin_reg;
  logic [1:0]        io_mode, bur_mode;
  logic [0:0]        io_csel, bur_csel;
  logic              pin_o, pin_oe_o, io_fb_o, pin_fb_o, bur_fb_o;
  int                total = 0, bad = 0;

  cpld_mc_pair #(.NUM_PT(NUM_PT), .NUM_CLK(2)) u_dut (
    .clk_i ({clk1, clk0}), .rst_ni (rst_ni), .set_ni (set_ni), .pin_i (pin_i),
    .io_pt_i (io_pt), .io_pt_en_i (io_en), .io_inv_i (io_inv), .io_mode_i (io_mode),
    .io_clk_sel_i (io_csel), .io_drive_i (io_drive),
    .bur_pt_i (bur_pt), .bur_pt_en_i (bur_en), .bur_inv_i (bur_inv), .bur_mode_i (bur_mode),
    .bur_clk_sel_i (bur_csel), .bur_pin_reg_i (bur_pin_reg),
    .pin_o (pin_o), .pin_oe_o (pin_oe_o), .io_fb_o (io_fb_o), .pin_fb_o (pin_fb_o),
    .bur_fb_o (bur_fb_o)
  );

  always #(CLK_PERIOD/2) clk0 = ~clk0;

  task automatic chk(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // both clock lines low: safe to change configuration or pulse clk1
  task automatic sync();
    @(negedge clk0); #1;
  endtask

  task automatic after_edge();
    @(posedge clk0); #2;
  endtask

  task automatic pulse1();
    clk1 = 1'b1; #1; clk1 = 1'b0; #1;
  endtask

  task automatic t_reset();
    rst_ni = 1'b0; set_ni = 1'b1; pin_i = 1'b0;
    io_pt = '0; io_en = '0; io_inv = 1'b0; io_mode = 2'd1; io_csel = 1'b0; io_drive = 1'b1;
    bur_pt = '0; bur_en = '0; bur_inv = 1'b0; bur_mode = 2'd1; bur_csel = 1'b0; bur_pin_reg = 1'b0;
    #3;
    chk("R7 reset io", io_fb_o, 1'b0);
    chk("R7 reset bur", bur_fb_o, 1'b0);
    repeat (2) @(posedge clk0);
    sync(); rst_ni = 1'b1;
  endtask

  task automatic t_wire();
    sync(); io_mode = 2'd0;
    io_pt = 16'h0010; io_en = 16'h0010; #1;
    chk("R1 one term", pin_o, 1'b1);
    io_en = '0; io_pt = '1; #1;
    chk("R1 no terms", pin_o, 1'b0);
    io_pt = 16'h0001; io_en = 16'hfffe; #1;
    chk("R1 masked term", io_fb_o, 1'b0);
    io_inv = 1'b1; io_en = '0; #1;
    chk("R2 invert empty", pin_o, 1'b1);
    io_pt = 16'h8000; io_en = 16'h8000; #1;
    chk("R3 wire inverted", io_fb_o, 1'b0);
    io_inv = 1'b0;
  endtask

  task automatic t_dff();
    sync(); io_mode = 2'd1; io_csel = 1'b0; io_pt = 16'h0004; io_en = 16'h0000;
    after_edge();
    chk("R4 capture 0", io_fb_o, 1'b0);
    sync(); io_en = 16'h0004; #1;
    chk("R4 no edge yet", io_fb_o, 1'b0);
    after_edge();
    chk("R4 capture 1", io_fb_o, 1'b1);
    sync(); io_csel = 1'b1; io_en = '0;
    after_edge(); after_edge();
    chk("R4 other line ignored", io_fb_o, 1'b1);
    sync(); pulse1();
    chk("R4 clk1 capture", io_fb_o, 1'b0);
  endtask

  task automatic t_tff();
    sync(); io_mode = 2'd2; io_csel = 1'b0; io_en = '0;
    set_ni = 1'b0; #1; set_ni = 1'b1; #1;
    chk("R7 preset to 1", io_fb_o, 1'b1);
    io_pt = 16'h0100; io_en = 16'h0100;
    after_edge();
    chk("R5 toggle 1->0", io_fb_o, 1'b0);
    after_edge();
    chk("R5 toggle 0->1", io_fb_o, 1'b1);
    sync(); io_en = '0;
    after_edge();
    chk("R5 hold on 0", io_fb_o, 1'b1);
  endtask

  task automatic t_latch();
    sync(); io_mode = 2'd3; io_csel = 1'b1; io_en = '0;
    clk1 = 1'b1; #1;
    chk("R6 open 0", io_fb_o, 1'b0);
    io_en = 16'h0100; #1;
    chk("R6 open 1", io_fb_o, 1'b1);
    clk1 = 1'b0; #1; io_en = '0; #1;
    chk("R6 hold", io_fb_o, 1'b1);
  endtask

  task automatic t_async();
    sync(); io_mode = 2'd1; io_csel = 1'b0; io_en = 16'h0100;
    after_edge();
    sync(); rst_ni = 1'b0; set_ni = 1'b0; #1;
    chk("R7 clear wins", io_fb_o, 1'b0);
    set_ni = 1'b1; #1; rst_ni = 1'b1; #1;
    chk("R7 stays clear", io_fb_o, 1'b0);
    io_en = '0; set_ni = 1'b0; #1;
    chk("R7 preset alone", io_fb_o, 1'b1);
    set_ni = 1'b1; #1;
    sync(); io_mode = 2'd0; io_en = 16'h0100; rst_ni = 1'b0; #1;
    chk("R7 wire ignores clear", pin_o, 1'b1);
    rst_ni = 1'b1; #1;
  endtask

  task automatic t_pin();
    sync(); io_mode = 2'd0; io_en = 16'h0100; io_drive = 1'b0; pin_i = 1'b1; #1;
    chk("R8 oe low", pin_oe_o, 1'b0);
    chk("R8 pin forward 1", pin_fb_o, 1'b1);
    pin_i = 1'b0; #1;
    chk("R8 pin forward 0", pin_fb_o, 1'b0);
    chk("R9 feedback while input", io_fb_o, 1'b1);
    io_drive = 1'b1; pin_i = 1'b1; #1;
    chk("R8 oe high", pin_oe_o, 1'b1);
    chk("R8 forward off", pin_fb_o, 1'b0);
    chk("R8 pin drive", pin_o, 1'b1);
  endtask

  task automatic t_bur();
    sync(); io_mode = 2'd0; io_en = '0; io_drive = 1'b0;
    bur_mode = 2'd0; bur_pin_reg = 1'b0; bur_pt = 16'h0002; bur_en = 16'h0002; #1;
    chk("R10 bur value", bur_fb_o, 1'b1);
    chk("R10 pin untouched", pin_o, 1'b0);
    chk("R10 oe untouched", pin_oe_o, 1'b0);
    bur_en = '0; #1;
    chk("R10 bur cleared", bur_fb_o, 1'b0);
    io_drive = 1'b1;
    bur_pin_reg = 1'b1; bur_mode = 2'd1; bur_csel = 1'b1; bur_inv = 1'b1; pin_i = 1'b1; #1;
    chk("R11 wait for edge", bur_fb_o, 1'b0);
    pulse1();
    chk("R11 capture pin, no invert", bur_fb_o, 1'b1);
    chk("R10 pin stays", pin_o, 1'b0);
    pin_i = 1'b0; #1;
    chk("R11 hold between edges", bur_fb_o, 1'b1);
    pulse1();
    chk("R11 capture pin 0", bur_fb_o, 1'b0);
    sync(); bur_mode = 2'd3; clk1 = 1'b1; pin_i = 1'b1; #1;
    chk("R11 latch open", bur_fb_o, 1'b1);
    clk1 = 1'b0; #1; pin_i = 1'b0; #1;
    chk("R11 latch hold", bur_fb_o, 1'b1);
    sync(); bur_mode = 2'd2; pin_i = 1'b1; pulse1();
    chk("R11 toggle code acts as D", bur_fb_o, 1'b1);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_wire();
    t_dff();
    t_tff();
    t_latch();
    t_async();
    t_pin();
    t_bur();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule